// File: doc/BRIEF.md
# Strobe-Count Buffer Clear Sequencer

This block sits on the device side of a magnetic-stripe reader. It waits until the track buffer reports that it holds a complete swipe. The buffer signals this through one of two flags, a zeroes flag or an auxiliary flag. While the buffer is in that state, the block counts rising edges of the host's shift strobe. The host must issue a fixed number of strobes to read the whole buffer out. The last of these strobes fires a one-cycle clear pulse toward the track memory. A cleared memory holds all zero bits, which the line shows as a high level.

When the clear fires, the block pulls the DATA line low as an acknowledge. It holds DATA low for a settle interval whose length is a parameter in clock cycles. It then releases DATA and re-arms the swipe decoder. If a card is still passing the head when the interval ends, the release and the re-arm wait until the card is gone. From the moment the buffer becomes ready until the re-arm, the decoder-arm output stays low, so the decoder ignores any new card activity.

Top module: `scs_clear_seq`

## Requirements
- R1: After reset the decoder is armed (`armed_o`=1), `clear_o` is 0, and `data_o` equals `data_in_i`.
- R2: While the block is armed, a high on `zero_flag_i` or on `aux_flag_i` moves it into the buffer-ready state, and `armed_o` falls one clock later.
- R3: Strobe edges that arrive while the block is armed are not counted.
- R4: `clear_o` pulses high for exactly one cycle, as the result of rising strobe edge number CLEAR_COUNT (default 2+16+8*3*608 = 14,610) counted from the moment buffer-ready is entered. No earlier edge produces a pulse.
- R5: From the cycle `clear_o` is high until the re-arm, `data_o` is 0 whatever the value of `data_in_i`.
- R6: If no swipe is active, `data_o` stays low for exactly SETTLE_CYCLES cycles, counting the cycle of the clear pulse. After that `armed_o` is 1 and `data_o` again follows `data_in_i`.
- R7: If `swipe_active_i` is high when the settle interval ends, `data_o` stays low and `armed_o` stays 0 until `swipe_active_i` falls. The re-arm happens on the next clock.
- R8: Flag pulses that arrive while the buffer is ready do not restart or alter the strobe count.
- R9: A reset in the middle of a count discards the partial count. After the block re-enters buffer-ready, the full CLEAR_COUNT edges are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Host shift strobe (asynchronous, synchronised inside) |
| zero_flag_i | input | 1 | Buffer-ready indication through the zeroes flag |
| aux_flag_i | input | 1 | Buffer-ready indication through the auxiliary flag |
| swipe_active_i | input | 1 | A card is currently passing the head |
| data_in_i | input | 1 | DATA level from the shift-out path |
| data_o | output | 1 | DATA line toward the host |
| clear_o | output | 1 | One-cycle clear pulse to the track memory |
| armed_o | output | 1 | Swipe decoder enabled |

## Verification
The hardest case to reach is the exact clear edge. To show the pulse comes on edge 14,610 and not one edge early or late, the bench must drive the full default count, with no shortened parameter. It adds edges while armed and a stray flag in the middle of the count, so that an off-by-one or a restarted counter lands on the wrong edge. The stretched settle needs a card held active across the end of the interval. The bench raises `swipe_active_i` before the final strobe and drops it a known number of cycles after the interval has ended, then measures the total low time on `data_o`. A reset partway through a count, followed by a second complete readout, exposes any count left over from before the reset.

// File: rtl/scs_pkg.sv
package scs_pkg;
   typedef enum logic [1:0] {
      ST_ARMED  = 2'd0,
      ST_READY  = 2'd1,
      ST_SETTLE = 2'd2,
      ST_HOLD   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/scs_edge_rise.sv
module scs_edge_rise #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic lvl;
   logic lvl_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = level_i;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= level_i;
         end
         assign lvl = s_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], level_i};
         end
         assign lvl = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise_o = lvl & ~lvl_q;
endmodule

// File: rtl/scs_strobe_counter.sv
module scs_strobe_counter #(
   parameter int CLEAR_COUNT = 14610
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic step_i,
   output logic hit_o
);
   localparam int CW = (CLEAR_COUNT > 2) ? $clog2(CLEAR_COUNT) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLEAR_COUNT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!enable_i)        cnt_q <= '0;
      else if (step_i && !hit_o) cnt_q <= cnt_q + 1'b1;
   end

   assign hit_o = enable_i & step_i & (cnt_q == LAST);
endmodule

// File: rtl/scs_settle_timer.sv
module scs_settle_timer #(
   parameter int SETTLE_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int TW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [TW-1:0] LAST = TW'(SETTLE_CYCLES - 1);

   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tmr_q <= '0;
      else if (!run_i)      tmr_q <= '0;
      else if (tmr_q != LAST) tmr_q <= tmr_q + 1'b1;
   end

   assign done_o = run_i & (tmr_q == LAST);
endmodule

// File: rtl/scs_clear_seq.sv
module scs_clear_seq
   import scs_pkg::*;
#(
   parameter int CLEAR_COUNT   = 2 + 16 + 8 * 3 * 608,
   parameter int SETTLE_CYCLES = 1000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic zero_flag_i,
   input  logic aux_flag_i,
   input  logic swipe_active_i,
   input  logic data_in_i,
   output logic data_o,
   output logic clear_o,
   output logic armed_o
);
   generate
      if (CLEAR_COUNT < 2) begin : g_bad_count
         $error("CLEAR_COUNT must be at least 2");
      end
      if (SETTLE_CYCLES < 2) begin : g_bad_settle
         $error("SETTLE_CYCLES must be at least 2");
      end
   endgenerate

   seq_state_e state_q, state_d;
   logic       strobe_rise;
   logic       count_hit;
   logic       settle_done;
   logic       clear_q;

   scs_edge_rise #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (strobe_i),
      .rise_o  (strobe_rise)
   );

   scs_strobe_counter #(.CLEAR_COUNT(CLEAR_COUNT)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (state_q == ST_READY),
      .step_i   (strobe_rise),
      .hit_o    (count_hit)
   );

   scs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == ST_SETTLE),
      .done_o (settle_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_ARMED:  if (zero_flag_i || aux_flag_i) state_d = ST_READY;
         ST_READY:  if (count_hit) state_d = ST_SETTLE;
         ST_SETTLE: if (settle_done) state_d = swipe_active_i ? ST_HOLD : ST_ARMED;
         ST_HOLD:   if (!swipe_active_i) state_d = ST_ARMED;
         default:   state_d = ST_ARMED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ARMED;
         clear_q <= 1'b0;
      end else begin
         state_q <= state_d;
         clear_q <= count_hit;
      end
   end

   assign clear_o = clear_q;
   assign armed_o = (state_q == ST_ARMED);
   assign data_o  = ((state_q == ST_SETTLE) || (state_q == ST_HOLD)) ? 1'b0 : data_in_i;
endmodule

// File: rtl/scs_clear_seq_chk.sv
module scs_clear_seq_chk
   import scs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input seq_state_e state,
   input logic       zero_flag_i,
   input logic       aux_flag_i,
   input logic       swipe_active_i,
   input logic       data_in_i,
   input logic       data_o,
   input logic       clear_o,
   input logic       armed_o
);
   p_reset_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o |-> (data_o == data_in_i));

   p_flag_enters_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && (zero_flag_i || aux_flag_i)) |=> !armed_o);

   p_clear_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear_o |=> !clear_o);

   p_clear_from_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear_o |-> $past(state == ST_READY));

   p_ack_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_o |-> (!data_o && !armed_o));

   p_swipe_blocks_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && swipe_active_i) |=> (!armed_o && !data_o));

   p_ready_ignores_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && !clear_o) |=> (state != ST_ARMED));
endmodule

bind scs_clear_seq scs_clear_seq_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .state          (state_q),
   .zero_flag_i    (zero_flag_i),
   .aux_flag_i     (aux_flag_i),
   .swipe_active_i (swipe_active_i),
   .data_in_i      (data_in_i),
   .data_o         (data_o),
   .clear_o        (clear_o),
   .armed_o        (armed_o)
);

// File: tb/sim_scs_clear_seq.sv
`timescale 1ns/1ps
module sim_scs_clear_seq;
   localparam int NCLR   = 2 + 16 + 8 * 3 * 608;
   localparam int SETTLE = 16;
   localparam int EXTRA  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 1'b0, zflag = 1'b0, aflag = 1'b0, swipe = 1'b0, din = 1'b1;
   logic data_o, clear_o, armed_o;

   int tests = 0;
   int fails = 0;
   int since_ready = 0;
   int exp_idx_q[$];
   int exp_low_q[$];
   bit measuring = 0;
   int low_cnt = 0;

   always #5 clk = ~clk;

   scs_clear_seq #(.CLEAR_COUNT(NCLR), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .zero_flag_i(zflag),
      .aux_flag_i(aflag), .swipe_active_i(swipe), .data_in_i(din),
      .data_o(data_o), .clear_o(clear_o), .armed_o(armed_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); strobe = 1'b1; since_ready++;
         @(negedge clk);
         @(negedge clk); strobe = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_flag(input bit use_aux, input bit restart);
      @(negedge clk);
      if (use_aux) aflag = 1'b1; else zflag = 1'b1;
      if (restart) since_ready = 0;
      @(negedge clk);
      aflag = 1'b0; zflag = 1'b0;
   endtask

   // monitor: pops expected clear index and settle length
   always @(negedge clk) begin
      if (measuring) begin
         if (data_o == 1'b0) low_cnt++;
         else begin
            measuring = 0;
            if (exp_low_q.size() == 0) chk(0, "R6", low_cnt, -1);
            else begin
               automatic int e = exp_low_q.pop_front();
               chk(low_cnt == e, "R6/R7 settle length", low_cnt, e);
            end
            chk(armed_o == 1'b1, "R6 rearm", armed_o, 1);
         end
      end
      if (clear_o) begin
         if (exp_idx_q.size() == 0) chk(0, "R4 unexpected clear", since_ready, -1);
         else begin
            automatic int e = exp_idx_q.pop_front();
            chk(since_ready == e, "R4 clear edge index", since_ready, e);
         end
         chk(data_o == 1'b0, "R5 ack low", data_o, 0);
         measuring = 1;
         low_cnt = 1;
      end
   end

   initial begin
      repeat (199000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(armed_o == 1'b1, "R1 armed", armed_o, 1);
      chk(clear_o == 1'b0, "R1 clear", clear_o, 0);
      chk(data_o == 1'b1, "R1 data follows", data_o, 1);
      rst_n = 1'b1;
      @(negedge clk); din = 1'b0;
      @(negedge clk);
      chk(data_o == 1'b0, "R1 data follows low", data_o, 0);
      din = 1'b1;

      // R3: strobes while armed must not count
      strobes(7);
      chk(armed_o == 1'b1, "R3 still armed", armed_o, 1);
      // R2 zero flag enters ready
      pulse_flag(1'b0, 1'b1);
      chk(armed_o == 1'b0, "R2 zero flag ready", armed_o, 0);
      strobes(7000);
      // R8: stray aux flag, count kept
      pulse_flag(1'b1, 1'b0);
      strobes(NCLR - 7001);
      repeat (6) @(negedge clk);
      chk(exp_idx_q.size() == 0 && !measuring, "R4 no early clear", since_ready, NCLR - 1);
      // R7: card passing across the end of settle
      exp_idx_q.push_back(NCLR);
      exp_low_q.push_back(SETTLE + EXTRA);
      swipe = 1'b1;
      din = 1'b1;
      strobes(1);
      repeat (SETTLE + EXTRA - 1) @(negedge clk);
      chk(armed_o == 1'b0, "R7 held while swipe", armed_o, 0);
      swipe = 1'b0;
      repeat (3) @(negedge clk);
      chk(exp_idx_q.size() == 0 && exp_low_q.size() == 0, "R4/R7 events seen", exp_low_q.size(), 0);

      // R9: reset in mid-count
      pulse_flag(1'b0, 1'b1);
      strobes(500);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(armed_o == 1'b1, "R9 reset rearms", armed_o, 1);
      strobes(3);
      pulse_flag(1'b1, 1'b1);
      chk(armed_o == 1'b0, "R2 aux flag ready", armed_o, 0);
      strobes(NCLR - 1);
      repeat (6) @(negedge clk);
      chk(exp_idx_q.size() == 0 && !measuring, "R9 no clear from stale count", since_ready, NCLR - 1);
      exp_idx_q.push_back(NCLR);
      exp_low_q.push_back(SETTLE);
      swipe = 1'b1;
      strobes(1);
      repeat (4) @(negedge clk);
      swipe = 1'b0;
      repeat (SETTLE + 6) @(negedge clk);
      chk(exp_idx_q.size() == 0 && exp_low_q.size() == 0, "R6 events seen", exp_low_q.size(), 0);
      din = 1'b0;
      @(negedge clk);
      chk(data_o == 1'b0 && armed_o == 1'b1, "R6 data follows after rearm", data_o, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule